// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Periodic Rate Generator

This block sits between a 32768 Hz time base and the counting core of a real-time clock. Every time-base tick arrives as a one-cycle enable, `tbEn`, on the system clock. A 15-bit prescale counter advances on each enabled tick. Its wrap marks the once-per-second update of the calendar. A short warning strobe comes a few ticks ahead of each update and opens a busy window. Software polls that window to avoid reading the time while it is changing.

A 3-bit divider field starts the chain, stops it, or holds it in reset. On release from reset the counter restarts at the half-way phase, so the first update comes exactly half a second later. A 4-bit rate field picks one tap of the same counter as a periodic event source. Each periodic event sets a sticky flag. The flag raises an interrupt when its enable is set, and a read strobe from the host clears it.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `updTick`, `uipWarn`, `uipBusy`, `perTick`, `perFlag` and `irqOut` are all 0.
- R2: While `divSel` is 3'b111 the chain is held and gives no strobe, and `uipBusy` is 0. After `divSel` changes to 3'b010, the first `updTick` follows exactly 16384 enabled ticks later.
- R3: With `divSel` at 3'b010, `updTick` is a one-cycle pulse, and it comes every 32768 enabled ticks.
- R4: `uipWarn` pulses 8 enabled ticks before each `updTick`. `uipBusy` rises with `uipWarn` and falls 64 enabled ticks after the update.
- R5: Any `divSel` value other than 3'b010 and 3'b111 freezes the counter without losing its phase. After the field returns to 3'b010, the update lands after the remaining tick count.
- R6: Cycles with `tbEn` low do not advance the chain, so every period is counted in enabled ticks.
- R7: For `rateSel` values 3 to 15, `perTick` has a period of 2^(rateSel-1) enabled ticks. Value 3 gives 4 ticks (8192 Hz) and value 15 gives 16384 ticks (2 Hz).
- R8: `rateSel` 1 has the same period as 8 (128 ticks). `rateSel` 2 has the same period as 9 (256 ticks). `rateSel` 0 gives no `perTick` and never sets `perFlag`.
- R9: `perFlag` sets on each `perTick` and holds until `flagClr` is high at a clock edge. A periodic event at the same edge as `flagClr` wins. `irqOut` is `perFlag` AND `pieEn`.
- R10: A change of `rateSel` takes effect at the next edge of the newly chosen tap, with no extra or shortened pulse. `perTick` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbEn | input | 1 | One-cycle enable per 32768 Hz time-base tick |
| divSel | input | 3 | Divider control: 010 run, 111 reset, other values stop |
| rateSel | input | 4 | Periodic rate code, 0 = off |
| pieEn | input | 1 | Periodic interrupt enable |
| flagClr | input | 1 | Host read strobe that clears the periodic flag |
| updTick | output | 1 | One-second update strobe |
| uipWarn | output | 1 | Pre-update warning strobe |
| uipBusy | output | 1 | Update window in progress |
| perTick | output | 1 | Periodic event strobe |
| perFlag | output | 1 | Sticky periodic flag |
| irqOut | output | 1 | Periodic interrupt request |

## Verification
Three cases are hard to reach from the ports: holding the phase through a stop, a rate change, and a clear that lands on the same edge as a periodic event. Each needs the bench to know the hidden counter value at an exact cycle. The bench gets this by releasing the divider from reset, which puts the counter at a known half-way value. It then counts enabled ticks from that point, so it knows how many ticks remain before the update. To land a clear on an event edge, the bench first sees a periodic pulse, then counts the cycles of the known period. Rate changes are applied on the cycle right after a slow-tap pulse, when every low counter bit is known to be zero.

// File: rtl/rtc_prescaler_pkg.sv
package rtc_prescaler_pkg;

  localparam logic [2:0] DIV_RUN = 3'b010;
  localparam logic [2:0] DIV_RST = 3'b111;

  typedef struct packed {
    logic       run;     // counter advances this cycle
    logic       load;    // counter forced to half-second phase
    logic       tapOn;   // periodic source active
    logic [3:0] tapIdx;  // counter bit whose falling edge is the event
  } preCtl_t;

  // Rate code to counter bit: code c (3..15) -> bit c-2, so the period
  // is 2^(c-1) ticks. Codes 1 and 2 reuse the taps of codes 8 and 9.
  function automatic logic [3:0] rateTap(input logic [3:0] code);
    case (code)
      4'd1:    return 4'd6;
      4'd2:    return 4'd7;
      4'd0:    return 4'd0;
      default: return code - 4'd2;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler_ctrl.sv
module rtc_prescaler_ctrl
  import rtc_prescaler_pkg::*;
(
  input  logic       tbEn,
  input  logic [2:0] divSel,
  input  logic [3:0] rateSel,
  output preCtl_t    ctl
);

  always_comb begin
    ctl.load   = (divSel == DIV_RST);
    ctl.run    = (divSel == DIV_RUN) && tbEn;
    ctl.tapOn  = (rateSel != 4'd0);
    ctl.tapIdx = rateTap(rateSel);
  end

endmodule

// File: rtl/rtc_prescaler_dp.sv
module rtc_prescaler_dp
  import rtc_prescaler_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int WARN_TICKS = 8,
  parameter int HOLD_TICKS = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  preCtl_t ctl,
  input  logic    pieEn,
  input  logic    flagClr,
  output logic    updTick,
  output logic    uipWarn,
  output logic    uipBusy,
  output logic    perTick,
  output logic    perFlag,
  output logic    irqOut
);

  localparam logic [CNT_W-1:0] FULL    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HALF    = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WARN_AT = FULL - CNT_W'(WARN_TICKS);
  localparam logic [CNT_W-1:0] HOLD_AT = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tapMask;
  logic             perEvt;

  // All bits up to and including the tap; the event is the tick on which
  // they are all ones, i.e. the tap bit falls on the following count.
  assign tapMask = FULL >> (CNT_W - 1 - int'(ctl.tapIdx));
  assign perEvt  = ctl.run && ctl.tapOn && ((cnt & tapMask) == tapMask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= HALF;
      updTick <= 1'b0;
      uipWarn <= 1'b0;
      uipBusy <= 1'b0;
      perTick <= 1'b0;
      perFlag <= 1'b0;
    end else begin
      updTick <= ctl.run && (cnt == FULL);
      uipWarn <= ctl.run && (cnt == WARN_AT);
      perTick <= perEvt;

      if (ctl.load)     cnt <= HALF;
      else if (ctl.run) cnt <= cnt + CNT_W'(1);

      if (ctl.load)                         uipBusy <= 1'b0;
      else if (ctl.run && cnt == WARN_AT)   uipBusy <= 1'b1;
      else if (ctl.run && cnt == HOLD_AT)   uipBusy <= 1'b0;

      if (perEvt)       perFlag <= 1'b1;
      else if (flagClr) perFlag <= 1'b0;
    end
  end

  assign irqOut = perFlag && pieEn;

  assert_load_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (cnt == HALF));
  assert_upd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    updTick |=> !updTick);
  assert_busy_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    updTick |-> uipBusy);
  assert_hold_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.run && !ctl.load) |=> $stable(cnt));
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (perFlag && !flagClr) |=> perFlag);
  assert_per_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    perTick |=> !perTick);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_prescaler_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int WARN_TICKS = 8,
  parameter int HOLD_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbEn,
  input  logic [2:0] divSel,
  input  logic [3:0] rateSel,
  input  logic       pieEn,
  input  logic       flagClr,
  output logic       updTick,
  output logic       uipWarn,
  output logic       uipBusy,
  output logic       perTick,
  output logic       perFlag,
  output logic       irqOut
);

  preCtl_t ctl;

  rtc_prescaler_ctrl u_ctrl (
    .tbEn    (tbEn),
    .divSel  (divSel),
    .rateSel (rateSel),
    .ctl     (ctl)
  );

  rtc_prescaler_dp #(
    .CNT_W      (CNT_W),
    .WARN_TICKS (WARN_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .pieEn   (pieEn),
    .flagClr (flagClr),
    .updTick (updTick),
    .uipWarn (uipWarn),
    .uipBusy (uipBusy),
    .perTick (perTick),
    .perFlag (perFlag),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/rtc_prescaler_bench.sv
module rtc_prescaler_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbEn = 1'b1;
  logic [2:0] divSel = 3'b111;
  logic [3:0] rateSel = 4'd0;
  logic       pieEn = 1'b0;
  logic       flagClr = 1'b0;
  logic       updTick, uipWarn, uipBusy, perTick, perFlag, irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_prescaler u_rtc_prescaler (
    .clk(clk), .rst_n(rst_n), .tbEn(tbEn), .divSel(divSel), .rateSel(rateSel),
    .pieEn(pieEn), .flagClr(flagClr), .updTick(updTick), .uipWarn(uipWarn),
    .uipBusy(uipBusy), .perTick(perTick), .perFlag(perFlag), .irqOut(irqOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic holdReset(input int n);
    @(negedge clk);
    divSel = 3'b111;
    repeat (n) @(negedge clk);
  endtask

  // Waits for a perTick, then returns the cycles to the next one.
  task automatic measure(input bit gap, output int interval);
    int w = 0;
    interval = -1;
    while (!perTick && w < 40000) begin
      @(negedge clk); w++;
      if (gap) tbEn = ~tbEn;
    end
    if (!perTick) return;
    w = 0;
    do begin
      @(negedge clk); w++;
      if (gap) tbEn = ~tbEn;
    end while (!perTick && w < 40000);
    if (perTick) interval = w;
    tbEn = 1'b1;
  endtask

  task automatic testReset();
    chk({updTick, uipWarn, uipBusy, perTick, perFlag, irqOut} == 6'b0,
        "R1 outputs in reset", int'({updTick, uipWarn, uipBusy, perTick, perFlag, irqOut}), 0);
    @(negedge clk); rst_n = 1'b1; rateSel = 4'd3; pieEn = 1'b1;
    @(negedge clk);
    chk({updTick, uipWarn, uipBusy, perTick, perFlag, irqOut} == 6'b0,
        "R1 outputs after reset", int'({updTick, uipWarn, uipBusy, perTick, perFlag, irqOut}), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (updTick || uipWarn || uipBusy || perTick) seen++;
      end
      chk(seen == 0, "R2 held chain silent", seen, 0);
    end
    pieEn = 1'b0;
  endtask

  task automatic testRelease();
    int firstUpd = -1, secondUpd = -1, warnAt = -1, wide = 0;
    bit b0 = 0, b1 = 0, b2 = 0, b3 = 0, prevUpd = 0;
    holdReset(4);
    rateSel = 4'd0;
    divSel = 3'b010;
    for (int n = 1; n <= 49160; n++) begin
      @(negedge clk);
      if (updTick && prevUpd) wide++;
      prevUpd = updTick;
      if (updTick) begin
        if (firstUpd < 0) firstUpd = n;
        else if (secondUpd < 0) secondUpd = n;
      end
      if (uipWarn && warnAt < 0) warnAt = n;
      if (n == 16375) b0 = uipBusy;
      if (n == 16376) b1 = uipBusy;
      if (n == 16447) b2 = uipBusy;
      if (n == 16448) b3 = uipBusy;
    end
    chk(firstUpd == 16384, "R2 first update after release", firstUpd, 16384);
    chk(secondUpd - firstUpd == 32768, "R3 update period", secondUpd - firstUpd, 32768);
    chk(wide == 0, "R3 update pulse width", wide, 0);
    chk(warnAt == 16376, "R4 warning lead", warnAt, 16376);
    chk(!b0 && b1, "R4 busy rises with warning", int'({b0, b1}), 1);
    chk(b2 && !b3, "R4 busy falls 64 ticks after update", int'({b2, b3}), 2);
  endtask

  task automatic testStop();
    int seen = 0, m = 0;
    holdReset(4);
    rateSel = 4'd0;
    divSel = 3'b010;
    repeat (100) @(negedge clk);
    divSel = 3'b011; rateSel = 4'd3;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (updTick || uipWarn || perTick) seen++;
    end
    chk(seen == 0, "R5 stopped chain silent", seen, 0);
    divSel = 3'b010; rateSel = 4'd0;
    do begin @(negedge clk); m++; end while (!updTick && m < 20000);
    chk(m == 16284, "R5 phase kept across stop", m, 16284);
  endtask

  task automatic testGap();
    int iv;
    holdReset(2);
    divSel = 3'b010; rateSel = 4'd3;
    measure(1'b1, iv);
    chk(iv == 8, "R6 half-rate enable doubles period", iv, 8);
  endtask

  task automatic testRates();
    int iv;
    int codes[5] = '{3, 4, 6, 9, 15};
    foreach (codes[i]) begin
      @(negedge clk);
      rateSel = 4'(codes[i]);
      measure(1'b0, iv);
      chk(iv == (1 << (codes[i] - 1)), $sformatf("R7 period code %0d", codes[i]),
          iv, 1 << (codes[i] - 1));
    end
  endtask

  task automatic testAlias();
    int iv, seen = 0;
    @(negedge clk); rateSel = 4'd1;
    measure(1'b0, iv);
    chk(iv == 128, "R8 code 1 aliases code 8", iv, 128);
    @(negedge clk); rateSel = 4'd2;
    measure(1'b0, iv);
    chk(iv == 256, "R8 code 2 aliases code 9", iv, 256);
    @(negedge clk); rateSel = 4'd0; flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (perTick || perFlag) seen++;
    end
    chk(seen == 0, "R8 code 0 silent", seen, 0);
  endtask

  task automatic testFlag();
    int w = 0;
    @(negedge clk); rateSel = 4'd3; pieEn = 1'b0;
    while (!perTick && w < 100) begin @(negedge clk); w++; end
    chk(perFlag == 1'b1, "R9 flag set by event", perFlag, 1);
    chk(irqOut == 1'b0, "R9 irq masked", irqOut, 0);
    pieEn = 1'b1; #1;
    chk(irqOut == 1'b1, "R9 irq enabled", irqOut, 1);
    @(negedge clk);
    chk(perFlag == 1'b1, "R9 flag sticky", perFlag, 1);
    flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    chk(perFlag == 1'b0 && irqOut == 1'b0, "R9 clear on read", perFlag, 0);
    // Now two edges past an event; the next event lands two edges later.
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
    chk(perTick == 1'b1 && perFlag == 1'b1, "R9 set wins over clear",
        int'({perTick, perFlag}), 3);
    pieEn = 1'b0;
  endtask

  task automatic testSwitch();
    int w = 0, k = 0;
    @(negedge clk); rateSel = 4'd15;
    while (!perTick && w < 40000) begin @(negedge clk); w++; end
    rateSel = 4'd3;
    do begin @(negedge clk); k++; end while (!perTick && k < 100);
    chk(k == 4, "R10 new rate at next tap edge", k, 4);
    k = 0;
    do begin @(negedge clk); k++; end while (!perTick && k < 100);
    chk(k == 4, "R10 steady after change", k, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testRelease();
    testStop();
    testGap();
    testRates();
    testAlias();
    testFlag();
    testSwitch();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule